// File: doc/BRIEF.md
# Grouped-Access Vector Register File

This block stores thirty-two vector registers, each `VLEN = 8 * VLENB` bits wide. Clients reach single elements rather than whole registers. Every read or write request carries four things: a base register, an element-width code, a signed group exponent and an element index inside the group. The block maps the index to a physical register and a bit slice. A group spans one, two, four or eight consecutive registers. Negative exponents are clamped to a one-register group.

A separate mask port expands one register into a per-element flag vector. Normal masking treats the unmasked setting as "all active". Carry masking treats it as "no carry in". Flags at or beyond the requested element count read as zero.

Every accepted write raises a one-cycle dirty pulse, so the surrounding core can mark the vector context as modified. Reads and masks are combinational from the stored state. A write updates the storage at the clock edge.

Top module: `vrf_grouped`

## Requirements
- R1: The file holds 32 registers of `8*VLENB` bits, selected by a 5-bit index. After reset every register reads as zero.
- R2: The width code `sew` selects the element width: 0 is 8 bits, 1 is 16, 2 is 32 and 3 is 64. Element e of a register sits in bits `[e*SEW +: SEW]`, with element 0 at the least significant end. A read returns the element zero-extended to 64 bits. A write changes only that slice.
- R3: Width codes 4 to 7 are illegal. A write with such a code changes no register and raises no dirty pulse. A read with such a code returns zero.
- R4: The group exponent `lmul` is a signed 3-bit value p. For p of 0 or more, the group covers 2^p registers. Group index i goes to register `(base + i / (VLEN/SEW)) mod 32`, as element `i mod (VLEN/SEW)` of that register.
- R5: A negative exponent is treated as 0, so the group is a single register.
- R6: An index at or beyond `2^p * VLEN/SEW` is out of range. A write with such an index changes nothing and raises no dirty pulse. A read with such an index returns zero.
- R7: Reads are combinational. A read of a register that is being written in the same cycle returns the value from before the write.
- R8: `dirty_o` is high in the cycle after each accepted write, and low otherwise.
- R9: In normal mask mode (`mk_carry_i=0`), flag i for i below the count is 1 when `mk_vm_i=1`. When `mk_vm_i=0`, it is bit i of the selected register.
- R10: In carry mode (`mk_carry_i=1`), every flag is 0 when `mk_vm_i=1`. When `mk_vm_i=0`, flag i below the count is bit i of the selected register.
- R11: Mask flags at positions equal to or above the count are 0. A count above VLEN acts as VLEN.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write request |
| wr_base_i | input | 5 | Write group base register |
| wr_sew_i | input | 3 | Write element width code |
| wr_lmul_i | input | 3 | Write group exponent, signed |
| wr_idx_i | input | log2(VLEN) | Write element index in group |
| wr_data_i | input | 64 | Write element value, low SEW bits used |
| rd_base_i | input | 5 | Read group base register |
| rd_sew_i | input | 3 | Read element width code |
| rd_lmul_i | input | 3 | Read group exponent, signed |
| rd_idx_i | input | log2(VLEN) | Read element index in group |
| rd_data_o | output | 64 | Read element, zero-extended |
| mk_reg_i | input | 5 | Mask source register |
| mk_vm_i | input | 1 | Unmasked select |
| mk_carry_i | input | 1 | Carry-mode select |
| mk_cnt_i | input | log2(VLEN)+1 | Number of flags requested |
| mk_o | output | VLEN | Per-element flags |
| dirty_o | output | 1 | Vector context modified pulse |

## Verification
The assertions check several properties on every cycle:
- illegal-width reads return zero, and illegal-width writes never produce a dirty pulse;
- no dirty pulse appears without a preceding write request;
- 8-bit reads carry no high bits;
- carry-mode unmasked flags are all zero;
- the number of active flags in normal unmasked mode equals the clamped count.

Other behaviours appear only through the bench's scenarios, where a behavioural model of the whole array is compared on every clock:
- the element-to-register mapping across a group, including wraparound past register 31;
- exponent clamping and out-of-range index rejection;
- preservation of neighbouring slices;
- read-before-write ordering.

// File: rtl/vrf_pkg.sv
package vrf_pkg;
  localparam int NREG = 32;
  localparam int REG_W = 5;
  localparam int ELEM_W = 64;

  function automatic logic [ELEM_W-1:0] sew_mask(input logic [1:0] code);
    unique case (code)
      2'd0: sew_mask = 64'h0000_0000_0000_00ff;
      2'd1: sew_mask = 64'h0000_0000_0000_ffff;
      2'd2: sew_mask = 64'h0000_0000_ffff_ffff;
      default: sew_mask = '1;
    endcase
  endfunction
endpackage

// File: rtl/vrf_locate.sv
// Maps (base, sew, lmul, idx) to a physical register and a bit offset.
module vrf_locate #(
  parameter int VLEN = 128,
  localparam int LV_W = $clog2(VLEN),
  localparam int SH_W = $clog2(LV_W + 1)
) (
  input  logic [4:0]        base_i,
  input  logic [2:0]        sew_i,
  input  logic signed [2:0] lmul_i,
  input  logic [LV_W-1:0]   idx_i,
  output logic              ok_o,
  output logic [4:0]        reg_o,
  output logic [LV_W-1:0]   off_o
);
  logic [2:0]      pow;
  logic [SH_W-1:0] shift;
  logic [LV_W-1:0] elem;

  always_comb begin
    pow   = lmul_i[2] ? 3'd0 : lmul_i;
    shift = SH_W'(LV_W - 3) - SH_W'(sew_i[1:0]);
    ok_o  = !sew_i[2] && ((idx_i >> (shift + SH_W'(pow))) == '0);
    reg_o = base_i + 5'(idx_i >> shift);  // wraps mod 32
    elem  = idx_i & LV_W'((LV_W'(1) << shift) - LV_W'(1));
    off_o = elem << (3'd3 + {1'b0, sew_i[1:0]});
  end
endmodule

// File: rtl/vrf_mask_expand.sv
module vrf_mask_expand #(
  parameter int VLEN = 128,
  localparam int CNT_W = $clog2(VLEN) + 1
) (
  input  logic [VLEN-1:0]  src_i,
  input  logic             vm_i,
  input  logic             carry_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic [VLEN-1:0]  flags_o
);
  logic [CNT_W-1:0] eff;
  assign eff = (cnt_i > CNT_W'(VLEN)) ? CNT_W'(VLEN) : cnt_i;

  for (genvar i = 0; i < VLEN; i++) begin : g_bit
    assign flags_o[i] = (CNT_W'(i) < eff) && (vm_i ? !carry_i : src_i[i]);
  end
endmodule

// File: rtl/vrf_grouped.sv
module vrf_grouped
  import vrf_pkg::*;
#(
  parameter int VLENB = 16,
  localparam int VLEN = VLENB * 8,
  localparam int LV_W = $clog2(VLEN),
  localparam int CNT_W = LV_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [4:0]        wr_base_i,
  input  logic [2:0]        wr_sew_i,
  input  logic signed [2:0] wr_lmul_i,
  input  logic [LV_W-1:0]   wr_idx_i,
  input  logic [63:0]       wr_data_i,
  input  logic [4:0]        rd_base_i,
  input  logic [2:0]        rd_sew_i,
  input  logic signed [2:0] rd_lmul_i,
  input  logic [LV_W-1:0]   rd_idx_i,
  output logic [63:0]       rd_data_o,
  input  logic [4:0]        mk_reg_i,
  input  logic              mk_vm_i,
  input  logic              mk_carry_i,
  input  logic [CNT_W-1:0]  mk_cnt_i,
  output logic [VLEN-1:0]   mk_o,
  output logic              dirty_o
);
  logic [VLEN-1:0] regs_q [NREG];
  logic            w_ok, r_ok;
  logic [4:0]      w_reg, r_reg;
  logic [LV_W-1:0] w_off, r_off;
  logic            w_go;
  logic [VLEN-1:0] w_mask, w_bits;

  vrf_locate #(.VLEN(VLEN)) u_wloc (
    .base_i(wr_base_i), .sew_i(wr_sew_i), .lmul_i(wr_lmul_i), .idx_i(wr_idx_i),
    .ok_o(w_ok), .reg_o(w_reg), .off_o(w_off)
  );

  vrf_locate #(.VLEN(VLEN)) u_rloc (
    .base_i(rd_base_i), .sew_i(rd_sew_i), .lmul_i(rd_lmul_i), .idx_i(rd_idx_i),
    .ok_o(r_ok), .reg_o(r_reg), .off_o(r_off)
  );

  assign w_go   = wr_en_i && w_ok;
  assign w_mask = VLEN'(sew_mask(wr_sew_i[1:0])) << w_off;
  assign w_bits = VLEN'(wr_data_i & sew_mask(wr_sew_i[1:0])) << w_off;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int r = 0; r < NREG; r++) regs_q[r] <= '0;
    end else if (w_go) begin
      for (int r = 0; r < NREG; r++)
        if (w_reg == REG_W'(r)) regs_q[r] <= (regs_q[r] & ~w_mask) | w_bits;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) dirty_o <= 1'b0;
    else         dirty_o <= w_go;
  end

  assign rd_data_o = r_ok ? (64'(regs_q[r_reg] >> r_off) & sew_mask(rd_sew_i[1:0])) : '0;

  vrf_mask_expand #(.VLEN(VLEN)) u_mask (
    .src_i(regs_q[mk_reg_i]), .vm_i(mk_vm_i), .carry_i(mk_carry_i),
    .cnt_i(mk_cnt_i), .flags_o(mk_o)
  );
endmodule

// File: rtl/vrf_grouped_chk.sv
module vrf_grouped_chk #(
  parameter int VLENB = 16,
  localparam int VLEN = VLENB * 8,
  localparam int CNT_W = $clog2(VLEN) + 1
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             wr_en_i,
  input logic [2:0]       wr_sew_i,
  input logic [2:0]       rd_sew_i,
  input logic [63:0]      rd_data_o,
  input logic             mk_vm_i,
  input logic             mk_carry_i,
  input logic [CNT_W-1:0] mk_cnt_i,
  input logic [VLEN-1:0]  mk_o,
  input logic             dirty_o
);
  // R3
  illegal_wr_clean_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && wr_sew_i[2] |=> !dirty_o);
  // R3
  illegal_rd_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_sew_i[2] |-> rd_data_o == '0);
  // R8
  dirty_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dirty_o |-> $past(wr_en_i));
  // R2
  byte_rd_width_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_sew_i == 3'd0 |-> rd_data_o[63:8] == '0);
  // R10
  carry_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mk_vm_i && mk_carry_i |-> mk_o == '0);
  // R9 R11
  active_count_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mk_vm_i && !mk_carry_i |->
      $countones(mk_o) == ((mk_cnt_i > CNT_W'(VLEN)) ? VLEN : int'(mk_cnt_i)));
  // R11
  zero_count_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mk_cnt_i == '0 |-> mk_o == '0);
endmodule

bind vrf_grouped vrf_grouped_chk #(.VLENB(VLENB)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .wr_sew_i(wr_sew_i),
  .rd_sew_i(rd_sew_i), .rd_data_o(rd_data_o), .mk_vm_i(mk_vm_i),
  .mk_carry_i(mk_carry_i), .mk_cnt_i(mk_cnt_i), .mk_o(mk_o), .dirty_o(dirty_o)
);

// File: tb/sim_vrf_grouped.sv
`timescale 1ns/1ps
module sim_vrf_grouped;
  localparam int VLENB = 16;
  localparam int VLEN = VLENB * 8;
  localparam int LV_W = $clog2(VLEN);
  localparam int CNT_W = LV_W + 1;

  logic clk = 0, rst_n = 0;
  always #4 clk = ~clk;

  logic              wr_en = 0;
  logic [4:0]        wr_base = 0, rd_base = 0, mk_reg = 0;
  logic [2:0]        wr_sew = 0, rd_sew = 0;
  logic signed [2:0] wr_lmul = 0, rd_lmul = 0;
  logic [LV_W-1:0]   wr_idx = 0, rd_idx = 0;
  logic [63:0]       wr_data = 0, rd_data;
  logic              mk_vm = 0, mk_carry = 0, dirty;
  logic [CNT_W-1:0]  mk_cnt = 0;
  logic [VLEN-1:0]   mk;

  int errors = 0, checks = 0;
  logic [VLEN-1:0] mdl [32];

  vrf_grouped #(.VLENB(VLENB)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_base_i(wr_base),
    .wr_sew_i(wr_sew), .wr_lmul_i(wr_lmul), .wr_idx_i(wr_idx), .wr_data_i(wr_data),
    .rd_base_i(rd_base), .rd_sew_i(rd_sew), .rd_lmul_i(rd_lmul), .rd_idx_i(rd_idx),
    .rd_data_o(rd_data), .mk_reg_i(mk_reg), .mk_vm_i(mk_vm), .mk_carry_i(mk_carry),
    .mk_cnt_i(mk_cnt), .mk_o(mk), .dirty_o(dirty)
  );

  function automatic bit place(input int base, code, lmul, idx, output int r, output int sh);
    int sew, per, pw;
    r = 0; sh = 0;
    if (code > 3) return 0;
    sew = 8 << code; per = VLEN / sew; pw = (lmul < 0) ? 0 : lmul;
    if (idx >= per * (1 << pw)) return 0;
    r = (base + idx / per) % 32;
    sh = (idx % per) * sew;
    return 1;
  endfunction

  function automatic logic [63:0] wmask(input int code);
    return (code == 3) ? '1 : ((64'd1 << (8 << code)) - 64'd1);
  endfunction

  function automatic logic [63:0] exp_read();
    int r, sh;
    if (!place(rd_base, rd_sew, int'(rd_lmul), rd_idx, r, sh)) return '0;
    return 64'(mdl[r] >> sh) & wmask(rd_sew);
  endfunction

  function automatic logic [VLEN-1:0] exp_mask();
    logic [VLEN-1:0] m = '0;
    int n = (mk_cnt > VLEN) ? VLEN : int'(mk_cnt);
    for (int i = 0; i < n; i++) m[i] = mk_vm ? !mk_carry : mdl[mk_reg][i];
    return m;
  endfunction

  task automatic chk(input string tag, input logic [VLEN-1:0] act, exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // inputs already set after a negedge; check comb outputs, clock, check dirty
  task automatic step(input string tag);
    int r, sh;
    bit acc;
    #1;
    chk(tag, VLEN'(rd_data), VLEN'(exp_read()));
    chk(mk_carry ? "R10" : ((mk_cnt == 0 || mk_cnt > VLEN) ? "R11" : "R9"), mk, exp_mask());
    @(posedge clk);
    acc = wr_en && place(wr_base, wr_sew, int'(wr_lmul), wr_idx, r, sh);
    if (acc) mdl[r] = (mdl[r] & ~(VLEN'(wmask(wr_sew)) << sh)) |
                      (VLEN'(wr_data & wmask(wr_sew)) << sh);
    @(negedge clk);
    chk("R8", VLEN'(dirty), VLEN'(acc));
  endtask

  task automatic setw(input logic en, input int b, s, l, i, input logic [63:0] d);
    wr_en = en; wr_base = 5'(b); wr_sew = 3'(s); wr_lmul = 3'(l); wr_idx = LV_W'(i); wr_data = d;
  endtask
  task automatic setr(input int b, s, l, i);
    rd_base = 5'(b); rd_sew = 3'(s); rd_lmul = 3'(l); rd_idx = LV_W'(i);
  endtask
  task automatic setm(input int r, input logic vm, cy, input int c);
    mk_reg = 5'(r); mk_vm = vm; mk_carry = cy; mk_cnt = CNT_W'(c);
  endtask

  initial begin
    #(8 * 200000);
    errors++; checks++;
    $display("FAIL watchdog: actual=running expected=done");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int r = 0; r < 32; r++) mdl[r] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset contents
    setr(17, 3, 0, 1); setm(17, 0, 0, VLEN); step("R1");
    // R2 element slicing at each width
    setw(1, 3, 0, 0, 5, 64'h1234_5678_9abc_deab); setr(3, 0, 0, 5); step("R2");
    setr(3, 0, 0, 5); setw(1, 3, 1, 0, 1, 64'hffff_0000_0000_c0de); step("R2");
    setr(3, 1, 0, 1); setw(1, 4, 3, 0, 1, 64'hdead_beef_cafe_f00d); step("R7");
    setr(4, 3, 0, 1); setw(1, 3, 2, 0, 3, 64'h5555_aaaa); step("R2");
    setr(3, 0, 0, 4); setw(0, 0, 0, 0, 0, 0); step("R2");
    setr(3, 2, 0, 3); step("R2");
    // R7 same-register write and read
    setw(1, 9, 0, 0, 0, 64'h77); setr(9, 0, 0, 0); step("R7");
    setw(0, 0, 0, 0, 0, 0); setr(9, 0, 0, 0); step("R7");
    // R3 illegal width
    setw(1, 9, 5, 0, 0, 64'h11); setr(9, 4, 0, 0); step("R3");
    setw(0, 0, 0, 0, 0, 0); setr(9, 0, 0, 0); step("R3");
    // R4 group of four, last element lands in base+3
    setw(1, 12, 0, 2, 3 * (VLEN / 8) + 2, 64'hc3); setr(15, 0, 0, 2); step("R4");
    setw(0, 0, 0, 0, 0, 0); setr(15, 0, 0, 2); step("R4");
    setr(12, 0, 2, 3 * (VLEN / 8) + 2); step("R4");
    // R4 wraparound past register 31
    setw(1, 30, 3, 2, 3 * (VLEN / 64), 64'h0123_4567_89ab_cdef); setr(1, 3, 0, 0); step("R4");
    setw(0, 0, 0, 0, 0, 0); setr(1, 3, 0, 0); step("R4");
    // R5 negative exponent clamps to one register
    setw(1, 20, 0, -2, VLEN / 8, 64'h99); setr(21, 0, 0, 0); step("R5");
    setw(1, 20, 0, -1, VLEN / 8 - 1, 64'h5a); setr(20, 0, -3, VLEN / 8); step("R5");
    setw(0, 0, 0, 0, 0, 0); setr(20, 0, 0, VLEN / 8 - 1); step("R5");
    // R6 index beyond the group
    setw(1, 22, 3, 1, 2 * (VLEN / 64), 64'h42); setr(22, 3, 1, 2 * (VLEN / 64)); step("R6");
    setw(0, 0, 0, 0, 0, 0); setr(24, 3, 0, 0); step("R6");
    // R9 R10 R11 masks
    setw(1, 2, 3, 0, 0, 64'hf0f0_1234_8001_a5a5); step("R2");
    setw(0, 0, 0, 0, 0, 0);
    setm(2, 0, 0, VLEN); step("R9");
    setm(2, 1, 0, 37); step("R9");
    setm(2, 1, 1, VLEN); step("R10");
    setm(2, 0, 1, 40); step("R10");
    setm(2, 0, 0, 0); step("R11");
    setm(2, 1, 0, VLEN + 9); step("R11");
    setm(2, 0, 0, 13); step("R11");
    // random traffic against the model
    for (int k = 0; k < 600; k++) begin
      int b;
      b = $urandom % 32;
      setw($urandom % 3 != 0, b, $urandom % 5, int'($urandom % 8) - 4, $urandom % VLEN,
           {$urandom, $urandom});
      if ($urandom % 2) setr(b, $urandom % 5, int'($urandom % 8) - 4, $urandom % VLEN);
      else setr($urandom % 32, $urandom % 5, int'($urandom % 8) - 4, $urandom % VLEN);
      setm($urandom % 32, $urandom % 2, $urandom % 2, $urandom % (VLEN + 20));
      step("R4");
    end
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule